// File: doc/BRIEF.md
# Routed Two-Bank Interrupt Controller

This block gathers thirty-two level-sensitive interrupt requests, split into two banks of sixteen, and drives five processor interrupt lines. Each bank has a pending register that samples its request inputs every clock and a read/write enable mask. A request takes part only while both its pending bit and its mask bit are set. Every enabled request is steered to one of the five lines. Most requests are steered by a programmable 3-bit route field, and the rest have a fixed route.

Software reaches the registers over a plain 16-bit bus: a window select, a byte offset, a write strobe, write data, and combinational read data. Each line comes with a registered "winner" code, so the service routine reads at once which request to handle. The winner is the lowest-numbered active request in bank 1 that is routed to that line. If bank 1 has none, it is the lowest-numbered one in bank 2. When no active request is routed to the line, the code reads as spurious.

Top module: `irq_route_unit`

## Requirements
- R1: Offset 0x00 of window 0 (`bus_win`=0) reads the bank-1 pending register, and offset 0x00 of window 1 reads the bank-2 pending register. Each pending register holds the request inputs sampled at the previous clock edge. Writes to either pending register have no effect.
- R2: The bank-1 mask sits at window 0 offset 0x0C and the bank-2 mask at window 1 offset 0x06. Both reset to 0x0000. A request is active only when its pending bit and its mask bit are both 1.
- R3: Route fields are 3 bits wide at bit positions 0, 3, 6, 9 and 12 of four route registers. These registers sit in window 0 at offset 0x04 (reg A), 0x06 (reg B), 0x1C (reg C) and 0x1E (reg D). Bank-1 pins 0, 1, 2, 3 and 8 use reg A slots 0 to 4. Bank-1 pins 9, 11 and 12 use reg B slots 0, 2 and 3. Bank-2 pins 0, 1, 3, 4 and 5 use reg C slots 0 to 4. Bank-2 pins 6 to 10 use reg D slots 0 to 4. Bits outside an existing field read 0 and ignore writes.
- R4: After reset, reg A reads 0x0040 (bank-1 pin 2 to line 1), reg C reads 0x0002 (bank-2 pin 0 to line 2), and regs B and D read 0. Bank-2 pin 2 has no field and is fixed to line 3. Every other request without a field is fixed to line 0.
- R5: A field written with a value of 5, 6 or 7 keeps its old value, while the legal fields in the same write still update. `route_err` is high for exactly the cycle after such a write.
- R6: `irq_out[k]` is a registered OR of all active requests routed to line k. It changes one clock after the pending or mask state that causes it.
- R7: `win_code[6k+5:6k]` is registered together with `irq_out`. Bit 5 is valid, bit 4 is the bank (0 = bank 1, 1 = bank 2) and bits 3:0 are the pin. Bank 1 beats bank 2 and a lower pin beats a higher one. The code is all zero (spurious) when no active request is routed to line k.
- R8: Any window/offset pair not named in R1 to R3 reads 0x0000, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_win | input | 1 | Register window select (0 = bank-1 window, 1 = bank-2 window) |
| bus_addr | input | 5 | Byte offset inside the window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for the addressed register |
| src_a | input | 16 | Bank-1 request levels |
| src_b | input | 16 | Bank-2 request levels |
| irq_out | output | 5 | Processor interrupt lines |
| win_code | output | 30 | Six-bit winner code per line |
| route_err | output | 1 | Pulse after a write that carried an illegal route value |

## Verification
A bad route field sends a request to the wrong line. This shows on `irq_out` and `win_code` two clocks after the request is raised, and on a readback of the route register in the cycle after the write. A fault in the priority scan appears only when two or more active requests share a line, so the stimulus packs many requests onto the same line across both banks. A mask or pending bit that sticks or is lost becomes visible one cycle later on a register read and one cycle after that on the lines.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int REG_W       = 16;
    localparam int BANK_SRC    = 16;
    localparam int N_BANK      = 2;
    localparam int N_SRC       = N_BANK * BANK_SRC;
    localparam int N_OUT       = 5;
    localparam int FLD_W       = 3;
    localparam int FLD_PER_REG = 5;
    localparam int N_ASG       = 4;
    localparam int ADDR_W      = 5;
    localparam int PIN_W       = $clog2(BANK_SRC);
    localparam int CODE_W      = PIN_W + 2;

    typedef logic [FLD_W-1:0]  route_t;
    typedef logic [REG_W-1:0]  word_t;

    localparam route_t ROUTE_MAX = route_t'(N_OUT - 1);

    // window 0 offsets
    localparam logic [ADDR_W-1:0] OFS_PEND   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_RTE_A  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_RTE_B  = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_MASK_A = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_RTE_C  = 5'h1C;
    localparam logic [ADDR_W-1:0] OFS_RTE_D  = 5'h1E;
    // window 1 offsets
    localparam logic [ADDR_W-1:0] OFS_MASK_B = 5'h06;

    localparam logic [N_ASG-1:0][REG_W-1:0] ASG_RST = {16'h0000, 16'h0002, 16'h0000, 16'h0040};

    typedef struct packed {
        logic                    has;
        logic [1:0]              reg_i;
        logic [2:0]              slot;
        route_t                  fixed;
    } fld_loc_t;

    typedef struct packed {
        word_t                         pend_a;
        word_t                         pend_b;
        word_t                         mask_a;
        word_t                         mask_b;
        logic [N_ASG-1:0][REG_W-1:0]   asg;
        logic                          err;
    } regs_st_t;

    typedef struct packed {
        logic [N_OUT-1:0]              irq;
        logic [N_OUT-1:0][CODE_W-1:0]  win;
    } out_st_t;

    // Where the route of global source s lives (bank 2 starts at BANK_SRC).
    function automatic fld_loc_t loc_of(input int s);
        fld_loc_t l;
        l = '{has: 1'b0, reg_i: 2'd0, slot: 3'd0, fixed: 3'd0};
        case (s)
            0:  l = '{1'b1, 2'd0, 3'd0, 3'd0};
            1:  l = '{1'b1, 2'd0, 3'd1, 3'd0};
            2:  l = '{1'b1, 2'd0, 3'd2, 3'd0};
            3:  l = '{1'b1, 2'd0, 3'd3, 3'd0};
            8:  l = '{1'b1, 2'd0, 3'd4, 3'd0};
            9:  l = '{1'b1, 2'd1, 3'd0, 3'd0};
            11: l = '{1'b1, 2'd1, 3'd2, 3'd0};
            12: l = '{1'b1, 2'd1, 3'd3, 3'd0};
            16: l = '{1'b1, 2'd2, 3'd0, 3'd0};
            17: l = '{1'b1, 2'd2, 3'd1, 3'd0};
            18: l = '{1'b0, 2'd0, 3'd0, 3'd3};
            19: l = '{1'b1, 2'd2, 3'd2, 3'd0};
            20: l = '{1'b1, 2'd2, 3'd3, 3'd0};
            21: l = '{1'b1, 2'd2, 3'd4, 3'd0};
            22: l = '{1'b1, 2'd3, 3'd0, 3'd0};
            23: l = '{1'b1, 2'd3, 3'd1, 3'd0};
            24: l = '{1'b1, 2'd3, 3'd2, 3'd0};
            25: l = '{1'b1, 2'd3, 3'd3, 3'd0};
            26: l = '{1'b1, 2'd3, 3'd4, 3'd0};
            default: l = '{1'b0, 2'd0, 3'd0, 3'd0};
        endcase
        return l;
    endfunction

    // True when slot k of route register r carries a field.
    function automatic logic slot_used(input int r, input int k);
        logic     u;
        fld_loc_t l;
        u = 1'b0;
        for (int s = 0; s < N_SRC; s++) begin
            l = loc_of(s);
            if (l.has && (l.reg_i == r[1:0]) && (l.slot == k[2:0]))
                u = 1'b1;
        end
        return u;
    endfunction

    localparam regs_st_t REGS_RST = '{pend_a: '0, pend_b: '0, mask_a: '0, mask_b: '0,
                                      asg: ASG_RST, err: 1'b0};

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         win,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         we,
    input  logic [REG_W-1:0]             wdata,
    input  logic [REG_W-1:0]             src_a,
    input  logic [REG_W-1:0]             src_b,
    output logic [REG_W-1:0]             pend_a,
    output logic [REG_W-1:0]             pend_b,
    output logic [REG_W-1:0]             mask_a,
    output logic [REG_W-1:0]             mask_b,
    output logic [N_ASG-1:0][REG_W-1:0]  asg,
    output logic [REG_W-1:0]             rdata,
    output logic                         err
);

    regs_st_t   st_d, st_q;
    logic       hit_mask_a, hit_mask_b, hit_asg, hit_pend;
    logic [1:0] asg_idx;
    route_t     fld_v;

    // address decode
    always_comb begin
        hit_pend   = (addr == OFS_PEND);
        hit_mask_a = !win && (addr == OFS_MASK_A);
        hit_mask_b =  win && (addr == OFS_MASK_B);
        hit_asg    = 1'b0;
        asg_idx    = 2'd0;
        if (!win) begin
            case (addr)
                OFS_RTE_A: begin hit_asg = 1'b1; asg_idx = 2'd0; end
                OFS_RTE_B: begin hit_asg = 1'b1; asg_idx = 2'd1; end
                OFS_RTE_C: begin hit_asg = 1'b1; asg_idx = 2'd2; end
                OFS_RTE_D: begin hit_asg = 1'b1; asg_idx = 2'd3; end
                default:   begin hit_asg = 1'b0; asg_idx = 2'd0; end
            endcase
        end
    end

    // next-state
    always_comb begin
        st_d        = st_q;
        st_d.pend_a = src_a;
        st_d.pend_b = src_b;
        st_d.err    = 1'b0;
        fld_v       = '0;
        if (we) begin
            if (hit_mask_a) st_d.mask_a = wdata;
            if (hit_mask_b) st_d.mask_b = wdata;
            if (hit_asg) begin
                for (int k = 0; k < FLD_PER_REG; k++) begin
                    if (slot_used(int'(asg_idx), k)) begin
                        fld_v = wdata[k*FLD_W +: FLD_W];
                        if (fld_v > ROUTE_MAX)
                            st_d.err = 1'b1;
                        else
                            st_d.asg[asg_idx][k*FLD_W +: FLD_W] = fld_v;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= REGS_RST;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (hit_pend)        rdata = win ? st_q.pend_b : st_q.pend_a;
        else if (hit_mask_a) rdata = st_q.mask_a;
        else if (hit_mask_b) rdata = st_q.mask_b;
        else if (hit_asg)    rdata = st_q.asg[asg_idx];
    end

    assign pend_a = st_q.pend_a;
    assign pend_b = st_q.pend_b;
    assign mask_a = st_q.mask_a;
    assign mask_b = st_q.mask_b;
    assign asg    = st_q.asg;
    assign err    = st_q.err;

endmodule

// File: rtl/irq_route_map.sv
module irq_route_map
    import irq_route_pkg::*;
(
    input  logic [N_ASG-1:0][REG_W-1:0]  asg,
    output logic [N_SRC-1:0][FLD_W-1:0]  route
);

    fld_loc_t loc;

    always_comb begin
        loc   = '0;
        route = '0;
        for (int s = 0; s < N_SRC; s++) begin
            loc = loc_of(s);
            if (loc.has)
                route[s] = asg[loc.reg_i][int'(loc.slot)*FLD_W +: FLD_W];
            else
                route[s] = loc.fixed;
        end
    end

endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb
    import irq_route_pkg::*;
#(
    parameter int LINE_ID = 0
) (
    input  logic [N_SRC-1:0]             active,
    input  logic [N_SRC-1:0][FLD_W-1:0]  route,
    output logic [CODE_W-1:0]            code
);

    localparam route_t MY_LINE = route_t'(LINE_ID);

    // descending scan: the last match written is the lowest global index
    always_comb begin
        code = '0;
        for (int s = N_SRC - 1; s >= 0; s--) begin
            if (active[s] && (route[s] == MY_LINE))
                code = {1'b1, (s >= BANK_SRC), PIN_W'(s % BANK_SRC)};
        end
    end

endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
    import irq_route_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_win,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [REG_W-1:0]          bus_wdata,
    output logic [REG_W-1:0]          bus_rdata,
    input  logic [REG_W-1:0]          src_a,
    input  logic [REG_W-1:0]          src_b,
    output logic [N_OUT-1:0]          irq_out,
    output logic [N_OUT*CODE_W-1:0]   win_code,
    output logic                      route_err
);

    logic [REG_W-1:0]                pend_a, pend_b, mask_a, mask_b;
    logic [N_ASG-1:0][REG_W-1:0]     asg;
    logic [N_SRC-1:0][FLD_W-1:0]     route;
    logic [N_SRC-1:0]                active;
    logic [N_OUT-1:0][CODE_W-1:0]    code_w;
    out_st_t                         out_d, out_q;

    irq_route_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .win    (bus_win),
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .src_a  (src_a),
        .src_b  (src_b),
        .pend_a (pend_a),
        .pend_b (pend_b),
        .mask_a (mask_a),
        .mask_b (mask_b),
        .asg    (asg),
        .rdata  (bus_rdata),
        .err    (route_err)
    );

    irq_route_map u_map (
        .asg   (asg),
        .route (route)
    );

    assign active = {pend_b & mask_b, pend_a & mask_a};

    for (genvar k = 0; k < N_OUT; k++) begin : g_line
        irq_route_arb #(.LINE_ID(k)) u_arb (
            .active (active),
            .route  (route),
            .code   (code_w[k])
        );
    end

    // line OR computed apart from the arbiters
    always_comb begin
        out_d     = '0;
        out_d.win = code_w;
        for (int k = 0; k < N_OUT; k++) begin
            for (int s = 0; s < N_SRC; s++) begin
                if (active[s] && (route[s] == route_t'(k)))
                    out_d.irq[k] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_out  = out_q.irq;
    assign win_code = out_q.win;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_route_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_we,
    input logic [REG_W-1:0]          src_a,
    input logic [REG_W-1:0]          src_b,
    input logic [REG_W-1:0]          pend_a,
    input logic [REG_W-1:0]          pend_b,
    input logic [REG_W-1:0]          mask_a,
    input logic [REG_W-1:0]          mask_b,
    input logic [N_ASG-1:0][REG_W-1:0] asg,
    input logic [N_OUT-1:0]          irq_out,
    input logic [N_OUT*CODE_W-1:0]   win_code,
    input logic                      route_err
);

    assert_pend_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_a == $past(src_a)) && (pend_b == $past(src_b)));

    assert_mask_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> (($past(mask_a) != '0) || ($past(mask_b) != '0)));

    assert_err_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        route_err |-> $past(bus_we));

    for (genvar r = 0; r < N_ASG; r++) begin : g_reg
        for (genvar k = 0; k < FLD_PER_REG; k++) begin : g_fld
            assert_field_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
                asg[r][k*FLD_W +: FLD_W] <= ROUTE_MAX);
        end
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_line
        assert_line_vs_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[k] == win_code[k*CODE_W + CODE_W - 1]);
    end

endmodule

bind irq_route_unit irq_route_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .src_a     (src_a),
    .src_b     (src_b),
    .pend_a    (pend_a),
    .pend_b    (pend_b),
    .mask_a    (mask_a),
    .mask_b    (mask_b),
    .asg       (asg),
    .irq_out   (irq_out),
    .win_code  (win_code),
    .route_err (route_err)
);

// File: tb/sim_irq_route_unit.sv
module sim_irq_route_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_win = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] src_a = '0;
    logic [15:0] src_b = '0;
    wire  [15:0] bus_rdata;
    wire  [4:0]  irq_out;
    wire  [29:0] win_code;
    wire         route_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_win(bus_win), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_a(src_a), .src_b(src_b), .irq_out(irq_out),
        .win_code(win_code), .route_err(route_err)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // reference state
    int          f_reg [32];
    int          f_slot[32];
    int          m_route[32];
    logic [15:0] m_pend_a, m_pend_b, m_mask_a, m_mask_b;
    logic [4:0]  e_irq;
    logic [29:0] e_code;
    logic        e_err;
    logic [31:0] lf = 32'h1234_5678;

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic set_fld(input int s, input int r, input int k);
        f_reg[s] = r;
        f_slot[s] = k;
    endtask

    task automatic model_reset();
        for (int s = 0; s < 32; s++) m_route[s] = 0;
        m_route[2] = 1; m_route[16] = 2; m_route[18] = 3;
        m_pend_a = '0; m_pend_b = '0; m_mask_a = '0; m_mask_b = '0;
        e_irq = '0; e_code = '0; e_err = 1'b0;
    endtask

    function automatic int asg_of(input logic w, input logic [4:0] a);
        if (w) return -1;
        case (a)
            5'h04: return 0;
            5'h06: return 1;
            5'h1C: return 2;
            5'h1E: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [15:0] model_rdata(input logic w, input logic [4:0] a);
        logic [15:0] v;
        int r;
        v = '0;
        r = asg_of(w, a);
        if (a == 5'h00) v = w ? m_pend_b : m_pend_a;
        else if (!w && a == 5'h0C) v = m_mask_a;
        else if (w && a == 5'h06) v = m_mask_b;
        else if (r >= 0) begin
            for (int s = 0; s < 32; s++)
                if (f_reg[s] == r) v = v | (16'(m_route[s]) << (3 * f_slot[s]));
        end
        return v;
    endfunction

    function automatic string tag_of(input logic w, input logic [4:0] a);
        if (a == 5'h00) return "R1";
        if ((!w && a == 5'h0C) || (w && a == 5'h06)) return "R2";
        if (asg_of(w, a) >= 0) return "R3";
        return "R8";
    endfunction

    task automatic model_edge();
        logic act;
        int r, v;
        e_irq = '0;
        e_code = '0;
        for (int o = 0; o < 5; o++) begin
            for (int s = 31; s >= 0; s--) begin
                act = (s < 16) ? (m_pend_a[s] & m_mask_a[s]) : (m_pend_b[s-16] & m_mask_b[s-16]);
                if (act && m_route[s] == o) begin
                    e_irq[o] = 1'b1;
                    e_code[o*6 +: 6] = {1'b1, (s >= 16), 4'(s % 16)};
                end
            end
        end
        e_err = 1'b0;
        if (bus_we) begin
            if (!bus_win && bus_addr == 5'h0C) m_mask_a = bus_wdata;
            if (bus_win && bus_addr == 5'h06) m_mask_b = bus_wdata;
            r = asg_of(bus_win, bus_addr);
            if (r >= 0) begin
                for (int s = 0; s < 32; s++) begin
                    if (f_reg[s] == r) begin
                        v = int'((bus_wdata >> (3 * f_slot[s])) & 16'h7);
                        if (v > 4) e_err = 1'b1;
                        else m_route[s] = v;
                    end
                end
            end
        end
        m_pend_a = src_a;
        m_pend_b = src_b;
    endtask

    task automatic compare();
        chk("R6", "irq_out", 32'(irq_out), 32'(e_irq));
        chk("R7", "win_code", 32'(win_code), 32'(e_code));
        chk("R5", "route_err", 32'(route_err), 32'(e_err));
        chk(tag_of(bus_win, bus_addr), "rdata", 32'(bus_rdata), 32'(model_rdata(bus_win, bus_addr)));
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic w, input logic [4:0] a, input logic [15:0] d);
        bus_win = w; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic sel(input logic w, input logic [4:0] a);
        bus_win = w; bus_addr = a;
        #1;
    endtask

    function automatic logic [31:0] lfsr_next(input logic [31:0] x);
        return x[31] ? ((x << 1) ^ 32'h04C1_1DB7) : (x << 1);
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 32; s++) begin f_reg[s] = -1; f_slot[s] = -1; end
        set_fld(0, 0, 0); set_fld(1, 0, 1); set_fld(2, 0, 2); set_fld(3, 0, 3); set_fld(8, 0, 4);
        set_fld(9, 1, 0); set_fld(11, 1, 2); set_fld(12, 1, 3);
        set_fld(16, 2, 0); set_fld(17, 2, 1); set_fld(19, 2, 2); set_fld(20, 2, 3); set_fld(21, 2, 4);
        set_fld(22, 3, 0); set_fld(23, 3, 1); set_fld(24, 3, 2); set_fld(25, 3, 3); set_fld(26, 3, 4);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4: reset routing readback; R2: masks clear
        sel(1'b0, 5'h04); chk("R4", "route reg A reset", 32'(bus_rdata), 32'h0040);
        sel(1'b0, 5'h06); chk("R4", "route reg B reset", 32'(bus_rdata), 32'h0000);
        sel(1'b0, 5'h1C); chk("R4", "route reg C reset", 32'(bus_rdata), 32'h0002);
        sel(1'b0, 5'h1E); chk("R4", "route reg D reset", 32'(bus_rdata), 32'h0000);
        sel(1'b0, 5'h0C); chk("R2", "mask A reset", 32'(bus_rdata), 32'h0000);
        sel(1'b1, 5'h06); chk("R2", "mask B reset", 32'(bus_rdata), 32'h0000);
        chk("R6", "irq_out reset", 32'(irq_out), 32'h0);

        // R2: masked-off requests stay quiet
        src_a = 16'hFFFF; src_b = 16'hFFFF;
        tick(); tick();
        chk("R2", "masked requests", 32'(irq_out), 32'h0);
        src_a = '0; src_b = '0;
        wr(1'b0, 5'h0C, 16'hFFFF);
        wr(1'b1, 5'h06, 16'hFFFF);
        tick();

        // R4: default routes; R6: one-cycle registered line
        src_a = 16'h0004;
        tick(); tick();
        chk("R4", "bank1 pin2 to line1", 32'(irq_out), 32'b00010);
        src_b = 16'h0004;
        tick(); tick();
        chk("R4", "bank2 pin2 fixed to line3", 32'(irq_out), 32'b01010);
        src_a = '0; src_b = '0;
        tick();
        chk("R6", "line still held one cycle", 32'(irq_out), 32'b01010);
        tick();
        chk("R6", "line drops after pend", 32'(irq_out), 32'b00000);

        // R7: lowest pin wins, bank 1 before bank 2, spurious code zero
        src_a = 16'h0110; src_b = 16'h0001;
        tick(); tick();
        chk("R7", "line0 lowest pin", 32'(win_code[5:0]), 32'b100100);
        chk("R7", "line2 bank2 pin0", 32'(win_code[17:12]), 32'b110000);
        chk("R7", "line4 spurious", 32'(win_code[29:24]), 32'h0);
        src_a = 16'h8000; src_b = 16'h0002;
        tick(); tick();
        chk("R7", "bank1 before bank2", 32'(win_code[5:0]), 32'b101111);
        src_a = '0; src_b = '0;
        tick(); tick();

        // R3: program route fields; unused bits dropped
        wr(1'b0, 5'h04, 16'hB460);
        sel(1'b0, 5'h04); chk("R3", "route reg A write", 32'(bus_rdata), 32'h3460);
        wr(1'b0, 5'h06, 16'h0022);
        sel(1'b0, 5'h06); chk("R3", "route reg B unused slot", 32'(bus_rdata), 32'h0002);
        src_a = 16'h0100;
        tick(); tick();
        chk("R3", "bank1 pin8 to line3", 32'(irq_out), 32'b01000);
        src_a = '0;

        // R5: illegal field kept, legal neighbours update, error pulse
        wr(1'b0, 5'h04, 16'h000F);
        chk("R5", "error pulse", 32'(route_err), 32'h1);
        sel(1'b0, 5'h04); chk("R5", "illegal field kept", 32'(bus_rdata), 32'h0008);
        tick();
        chk("R5", "error pulse ends", 32'(route_err), 32'h0);

        // R1: pending write ignored; R8: unmapped offsets inert
        wr(1'b0, 5'h00, 16'hFFFF);
        sel(1'b0, 5'h00); chk("R1", "pending not writable", 32'(bus_rdata), 32'h0000);
        wr(1'b0, 5'h10, 16'hFFFF);
        sel(1'b0, 5'h10); chk("R8", "unmapped read", 32'(bus_rdata), 32'h0000);
        wr(1'b1, 5'h0C, 16'h0000);
        sel(1'b0, 5'h0C); chk("R8", "wrong-window write inert", 32'(bus_rdata), 32'hFFFF);

        // mixed traffic against the reference model
        for (int n = 0; n < 4000; n++) begin
            lf = lfsr_next(lf);
            src_a = lf[15:0] & lf[31:16];
            lf = lfsr_next(lf);
            src_b = lf[15:0] & lf[31:16];
            lf = lfsr_next(lf);
            bus_win = lf[0];
            case (lf[3:1])
                3'd0: bus_addr = 5'h00;
                3'd1: bus_addr = 5'h04;
                3'd2: bus_addr = 5'h06;
                3'd3: bus_addr = 5'h0C;
                3'd4: bus_addr = 5'h1C;
                3'd5: bus_addr = 5'h1E;
                3'd6: bus_addr = 5'h08;
                default: bus_addr = 5'h12;
            endcase
            bus_we = (lf[7:4] < 4'd4);
            bus_wdata = lf[31:16];
            tick();
            bus_we = 1'b0;
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule